// File: doc/BRIEF.md
# Sixteen-Line Register-Mapped GPIO Port

This peripheral sits on a simple synchronous register bus and owns sixteen general-purpose lines. Software programs a direction mask and a level word. Each output line carries the AND of its level bit and its direction bit. The driven vector is recomputed only when software writes the direction or the level. Whenever the vector is recomputed, each line whose value changed gives a one-cycle change strobe, which a neighbouring block can use as an edge event.

Sixteen input lines also feed the level word. A rising edge on input n sets level bit n, and a falling edge clears it. This path ignores the direction mask and does not drive the outputs by itself. The new level reaches the outputs at the next direction or level write.

The block also holds a set of plain 16-bit control and interrupt bookkeeping registers, a read-only status word, and a power word with a forced-bit rule. It does not act on any of them.

Top module: `pio16_top`

## Requirements
- R1: Only address bits [5:0] are decoded, so any address whose low six bits match a register offset reaches that register. The offsets are: mode 0x00, card-detect 0x04, status 0x08, power 0x0C, card-control 0x10, interrupt-request 0x14, interrupt-mask 0x18, interrupt-status 0x1C, direction 0x20, level-write 0x24, level-read 0x28.
- R2: A write stores only bits [15:0] of the write data. The mode, card-detect, card-control and the three interrupt registers read back exactly what was last written to them.
- R3: A power write with data bit 7 set stores the data ORed with 0x8040. Any other power write stores the data unchanged.
- R4: The status register reads 0x0002, and writes to it have no effect.
- R5: Reads of offsets 0x2C to 0x3C and of non-aligned offsets return 0. Writes to them change no register.
- R6: A write to either the level-write or the level-read offset stores (data AND direction) into the level word. Reads from both offsets return the level word.
- R7: A read of the direction offset returns the direction word.
- R8: After a direction or level write, the output vector pin_o equals level AND direction. Between such writes, pin_o holds its value.
- R9: pin_chg_o pulses for exactly one cycle, in the cycle where pin_o takes its new value. It is set only on the bits that changed. It is zero in every cycle that does not follow a direction or level write.
- R10: A rising edge on pin_i[n] sets level bit n, and a falling edge clears it, whatever the direction. This happens one clock edge after the change and leaves pin_o and pin_chg_o untouched.
- R11: If an input edge and a level write land on the same clock edge, the input edge decides that bit. Every other bit takes (data AND direction). The outputs are then recomputed from the merged level.
- R12: After reset, every register, pin_o and pin_chg_o are 0, except status. Read data appears on rdata_o one cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address; low 6 bits decoded |
| wdata_i | input | 32 | Write data; low 16 bits used |
| rdata_o | output | 16 | Registered read data |
| pin_i | input | 16 | Input lines feeding the level word |
| pin_o | output | 16 | Driven line vector |
| pin_chg_o | output | 16 | One-cycle per-line change strobes |

## Verification
Two functions can land on the same clock edge: a bus write to the level word and an input-line edge. Both modify the level word. The bench provokes this by changing pin_i in the same half-cycle as it presents a level write. It uses a data word that disagrees with the input on the edged bits.

The bench then checks the level read-back, pin_o and pin_chg_o against a model. In that model the edged bits take the input value and every other bit takes the masked write data. Sweeps of walking and arithmetic direction and level patterns, issued through both level addresses, check the strobe vector as the XOR of the old and new driven vectors.

// File: rtl/pio16_pkg.sv
package pio16_pkg;

  localparam int DEC_W = 6;

  localparam logic [DEC_W-1:0] OFF_MODE = 6'h00;
  localparam logic [DEC_W-1:0] OFF_CDET = 6'h04;
  localparam logic [DEC_W-1:0] OFF_STAT = 6'h08;
  localparam logic [DEC_W-1:0] OFF_PWR  = 6'h0C;
  localparam logic [DEC_W-1:0] OFF_CCTL = 6'h10;
  localparam logic [DEC_W-1:0] OFF_IREQ = 6'h14;
  localparam logic [DEC_W-1:0] OFF_IMSK = 6'h18;
  localparam logic [DEC_W-1:0] OFF_IST  = 6'h1C;
  localparam logic [DEC_W-1:0] OFF_DIR  = 6'h20;
  localparam logic [DEC_W-1:0] OFF_LVLW = 6'h24;
  localparam logic [DEC_W-1:0] OFF_LVLR = 6'h28;

  localparam logic [15:0] STAT_RST   = 16'h0002;
  localparam int          PWR_TRIG   = 7;
  localparam logic [15:0] PWR_FORCE  = 16'h8040;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_CDET, SEL_STAT, SEL_PWR, SEL_CCTL, SEL_IREQ,
    SEL_IMSK, SEL_IST, SEL_DIR, SEL_LVLW, SEL_LVLR, SEL_NONE
  } reg_sel_e;

  // storage slots for plain control registers
  localparam int NCTL = 7;

  function automatic reg_sel_e off_to_sel(input logic [DEC_W-1:0] off);
    case (off)
      OFF_MODE: return SEL_MODE;
      OFF_CDET: return SEL_CDET;
      OFF_STAT: return SEL_STAT;
      OFF_PWR:  return SEL_PWR;
      OFF_CCTL: return SEL_CCTL;
      OFF_IREQ: return SEL_IREQ;
      OFF_IMSK: return SEL_IMSK;
      OFF_IST:  return SEL_IST;
      OFF_DIR:  return SEL_DIR;
      OFF_LVLW: return SEL_LVLW;
      OFF_LVLR: return SEL_LVLR;
      default:  return SEL_NONE;
    endcase
  endfunction

  function automatic reg_sel_e slot_sel(input int idx);
    case (idx)
      0:       return SEL_MODE;
      1:       return SEL_CDET;
      2:       return SEL_PWR;
      3:       return SEL_CCTL;
      4:       return SEL_IREQ;
      5:       return SEL_IMSK;
      default: return SEL_IST;
    endcase
  endfunction

endpackage

// File: rtl/pio16_decode.sv
module pio16_decode
  import pio16_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  logic unused_hi;
  assign unused_hi = ^addr_i[ADDR_W-1:DEC_W];

  assign sel_o = off_to_sel(addr_i[DEC_W-1:0]);

endmodule

// File: rtl/pio16_ctl_regs.sv
module pio16_ctl_regs
  import pio16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  reg_sel_e                sel_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NCTL-1:0][DW-1:0] ctl_o
);

  for (genvar g = 0; g < NCTL; g++) begin : g_slot
    localparam reg_sel_e MY_SEL = slot_sel(g);
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    if (MY_SEL == SEL_PWR) begin : g_pwr
      always_comb d = wdata_i[PWR_TRIG] ? (wdata_i | PWR_FORCE) : wdata_i;
    end else begin : g_plain
      always_comb d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (wr_i && sel_i == MY_SEL)   q <= d;
    end

    assign ctl_o[g] = q;
  end

  // R3
  pwr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_PWR && wdata_i[PWR_TRIG]) |=> ((ctl_o[2] & PWR_FORCE) == PWR_FORCE))
    else $error("power force bits missing");

  // R3
  pwr_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_PWR && !wdata_i[PWR_TRIG]) |=> (ctl_o[2] == $past(wdata_i)))
    else $error("power plain write altered");

endmodule

// File: rtl/pio16_line_core.sv
module pio16_line_core #(
  parameter int NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dir_we_i,
  input  logic            lvl_we_i,
  input  logic [NPIN-1:0] wdata_i,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] chg_o
);

  logic [NPIN-1:0] dir_q, lvl_q, drv_q, chg_q, pin_q;
  logic [NPIN-1:0] dir_d, lvl_d, drv_d, ev;
  logic            upd;

  assign upd   = dir_we_i | lvl_we_i;
  assign dir_d = dir_we_i ? wdata_i : dir_q;

  // input edge overrides a same-cycle bus level write per bit
  for (genvar n = 0; n < NPIN; n++) begin : g_line
    logic base;
    assign ev[n]    = pin_i[n] ^ pin_q[n];
    assign base     = lvl_we_i ? (wdata_i[n] & dir_q[n]) : lvl_q[n];
    assign lvl_d[n] = ev[n] ? pin_i[n] : base;
    assign drv_d[n] = lvl_d[n] & dir_d[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
      drv_q <= '0;
      chg_q <= '0;
      pin_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      pin_q <= pin_i;
      chg_q <= upd ? (drv_q ^ drv_d) : '0;
      if (upd) drv_q <= drv_d;
    end
  end

  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
  assign pin_o = drv_q;
  assign chg_o = chg_q;

  // R9
  chg_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o == (pin_o ^ $past(pin_o)))
    else $error("strobe does not match output change");

  // R9
  chg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> chg_o == '0)
    else $error("strobe without update");

  // R8
  pin_in_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~dir_o) == '0)
    else $error("output driven outside direction");

  // R8
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(pin_o))
    else $error("output moved without update");

  // R6
  lvl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_we_i && ev == '0) |=> (lvl_o & ~dir_o) == '0)
    else $error("level write not masked");

endmodule

// File: rtl/pio16_top.sv
module pio16_top
  import pio16_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int NPIN   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_chg_o
);

  localparam int DW = 16;

  reg_sel_e                sel;
  logic                    wr, rd;
  logic [DW-1:0]           wd;
  logic [NCTL-1:0][DW-1:0] ctl;
  logic [NPIN-1:0]         dir, lvl;
  logic [DW-1:0]           rd_mux, rdata_q;
  logic                    unused_wd;

  assign wd        = wdata_i[DW-1:0];
  assign unused_wd = ^wdata_i[BUS_W-1:DW];
  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;

  pio16_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  pio16_ctl_regs #(.DW(DW)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .sel_i   (sel),
    .wdata_i (wd),
    .ctl_o   (ctl)
  );

  pio16_line_core #(.NPIN(NPIN)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_we_i (wr && sel == SEL_DIR),
    .lvl_we_i (wr && (sel == SEL_LVLW || sel == SEL_LVLR)),
    .wdata_i  (wd[NPIN-1:0]),
    .pin_i    (pin_i),
    .dir_o    (dir),
    .lvl_o    (lvl),
    .pin_o    (pin_o),
    .chg_o    (pin_chg_o)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MODE:           rd_mux = ctl[0];
      SEL_CDET:           rd_mux = ctl[1];
      SEL_STAT:           rd_mux = STAT_RST;
      SEL_PWR:            rd_mux = ctl[2];
      SEL_CCTL:           rd_mux = ctl[3];
      SEL_IREQ:           rd_mux = ctl[4];
      SEL_IMSK:           rd_mux = ctl[5];
      SEL_IST:            rd_mux = ctl[6];
      SEL_DIR:            rd_mux = DW'(dir);
      SEL_LVLW, SEL_LVLR: rd_mux = DW'(lvl);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R4
  stat_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_STAT) |=> rdata_o == STAT_RST)
    else $error("status read wrong");

  // R5
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_NONE) |=> rdata_o == '0)
    else $error("unmapped read nonzero");

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o))
    else $error("read data moved without read");

endmodule

// File: tb/pio16_tb.sv
module pio16_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] rdata, pin_in = '0, pin_out, pin_chg;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_dir = '0, m_lvl = '0, m_drv = '0;
  logic [15:0] obs_chg, obs_pin;

  always #2 clk = ~clk;

  pio16_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_chg_o(pin_chg)
  );

  task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    obs_chg = pin_chg; obs_pin = pin_out;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    d = rdata;
  endtask

  task automatic rd_check(input string t, input logic [11:0] a, input logic [15:0] exp);
    logic [15:0] v;
    bus_rd(a, v);
    check(t, v, exp);
  endtask

  // line write with model update and output/strobe checks
  task automatic line_wr(input bit is_dir, input logic [11:0] a, input logic [31:0] d);
    logic [15:0] nd;
    if (is_dir) m_dir = d[15:0];
    else        m_lvl = d[15:0] & m_dir;
    nd = m_lvl & m_dir;
    bus_wr(a, d);
    check("R8 pin_o", obs_pin, nd);
    check("R9 strobe", obs_chg, m_drv ^ nd);
    m_drv = nd;
    @(negedge clk);
    check("R9 strobe one cycle", pin_chg, 16'h0);
  endtask

  task automatic set_pins(input logic [15:0] v);
    logic [15:0] ev;
    ev = v ^ pin_in;
    @(negedge clk); pin_in = v;
    @(negedge clk);
    m_lvl = (m_lvl & ~ev) | (v & ev);
    check("R10 no re-eval pin_o", pin_out, m_drv);
    check("R10 no strobe", pin_chg, 16'h0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] ctl_off [6];
    logic [15:0] v;
    ctl_off = '{12'h000, 12'h004, 12'h010, 12'h014, 12'h018, 12'h01C};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    check("R12 reset pin_o", pin_out, 16'h0);
    check("R12 reset strobe", pin_chg, 16'h0);
    check("R12 reset rdata", rdata, 16'h0);
    for (int i = 0; i < 11; i++)
      if (i != 2) rd_check("R12 reset reg", 12'(i * 4), 16'h0);
    rd_check("R4 status reset", 12'h008, 16'h0002);

    // R2 plain storage, upper data bits dropped
    for (int k = 0; k < 6; k++)
      for (int p = 0; p < 4; p++) begin
        v = 16'((k + 1) * 16'h1357 + p * 16'h4C1B);
        bus_wr(ctl_off[k], {16'hBEEF, v});
        rd_check("R2 readback", ctl_off[k], v);
      end

    // R1 aliasing above offset 0x3F
    bus_wr(12'hFC4, 32'h0000_9A5E);
    rd_check("R1 alias write", 12'h004, 16'h9A5E);
    rd_check("R1 alias read", 12'h844, 16'h9A5E);

    // R3 power rule across bit patterns
    for (int p = 0; p < 16; p++) begin
      v = 16'(p * 16'h1111) ^ 16'(p << 5);
      bus_wr(12'h00C, {16'h0, v});
      rd_check("R3 power", 12'h00C, v[7] ? (v | 16'h8040) : v);
    end

    // R4 status ignores writes
    bus_wr(12'h008, 32'h0000_FFFF);
    rd_check("R4 status write ignored", 12'h008, 16'h0002);

    // R5 unmapped offsets
    bus_wr(12'h000, 32'h0000_1234);
    for (int o = 12'h2C; o < 12'h40; o++) begin
      bus_wr(12'(o), 32'h0000_FFFF);
      rd_check("R5 unmapped read", 12'(o), 16'h0);
    end
    rd_check("R5 unmapped write ignored", 12'h000, 16'h1234);
    rd_check("R5 unmapped write ignored dir", 12'h020, 16'h0);
    check("R5 pin_o untouched", pin_out, 16'h0);

    // R8/R9 walking direction over full level
    line_wr(1, 12'h020, 32'h0000_FFFF);
    line_wr(0, 12'h024, 32'h0000_FFFF);
    for (int i = 0; i < 16; i++) begin
      line_wr(1, 12'h020, 32'(16'h1 << i));
      rd_check("R7 dir read", 12'h020, 16'h1 << i);
    end

    // R6 level writes through both addresses, masked by direction
    for (int i = 0; i < 24; i++) begin
      v = 16'(i * 16'h1F35) ^ 16'h5A3C;
      if (i % 2 == 0) line_wr(1, 12'h020, {16'hDEAD, v});
      else            line_wr(0, (i % 4 == 1) ? 12'h024 : 12'h028, {16'hDEAD, v});
      rd_check("R7 dir", 12'h020, m_dir);
      rd_check("R6 level via write addr", 12'h024, m_lvl);
      rd_check("R6 level via read addr", 12'h028, m_lvl);
    end

    // R10 input edges, unmasked, no output re-evaluation
    line_wr(1, 12'h020, 32'h0000_00FF);
    line_wr(0, 12'h024, 32'h0000_000F);
    set_pins(16'hF0F0);
    rd_check("R10 rise sets level", 12'h028, m_lvl);
    line_wr(1, 12'h020, 32'h0000_00FF);
    set_pins(16'h00F0);
    rd_check("R10 fall clears level", 12'h024, m_lvl);
    line_wr(0, 12'h024, 32'h0000_00FF);

    // R11 same-edge input edge and level write
    begin
      logic [15:0] ev, nd, newp, d;
      newp = 16'h0F0F;
      d    = 16'h0030;
      ev   = newp ^ pin_in;
      m_lvl = ((d & m_dir) & ~ev) | (newp & ev);
      nd   = m_lvl & m_dir;
      @(negedge clk); pin_in = newp; req = 1; we = 1; addr = 12'h024; wdata = {16'h0, d};
      @(negedge clk); req = 0; we = 0;
      check("R11 collision pin_o", pin_out, nd);
      check("R11 collision strobe", pin_chg, m_drv ^ nd);
      m_drv = nd;
      rd_check("R11 collision level", 12'h028, m_lvl);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule